// File: doc/BRIEF.md
# SPI Flash Stream Reader

This block is an SPI master that fetches a bitstream from a serial flash device. After a start pulse it lowers chip select and shifts out a single read command: an opcode byte and a 24-bit start address. It then clocks a set number of dummy bits. From that point it reads the flash as one endless stream. It sends no further command and delivers every received byte on a byte-wide output with a one-cycle valid strobe.

The read opcode, the start address, the dummy bit count, the SCLK divider and the SPI clock polarity and phase are all parameters. This lets one block serve flash parts that use different read instructions. The stream continues until a stop pulse arrives. The stop takes effect only on a data-byte boundary, so downstream logic never receives a partial byte.

Top module: `spi_stream_reader`

## Requirements
- R1: While reset is held and after it is released with no start, `spi_cs_n` is 1, `spi_sclk` rests at the CPOL level, `spi_mosi` is 0 and `rd_valid` is 0.
- R2: After a start pulse from idle, the first 32 bits shifted out on `spi_mosi` are the OPCODE parameter (default 0x0B) followed by the 24-bit START_ADDR, each sent most significant bit first.
- R3: After the 32 command bits, DUMMY_BITS further clocks are issued whose MISO values are discarded. The first data bit is the one sampled on clock number 33 + DUMMY_BITS, so the first `rd_valid` follows sampling clock 40 + DUMMY_BITS.
- R4: Data bytes are assembled MSB first: the first bit received in a byte lands in `rd_data[7]`. `rd_valid` is high for exactly one cycle per byte. The stream continues indefinitely with chip select held low and no further command.
- R5: SCLK idles at CPOL. With CPHA=0 MISO is sampled on the first edge of each bit; with CPHA=1 it is sampled on the second edge. `spi_mosi` changes only on the opposite, non-sampling edge.
- R6: Each SCLK half period lasts DIV system clock cycles, so a full SCLK period is 2*DIV cycles.
- R7: A stop pulse raises `spi_cs_n` only after the data byte in progress has been fully received, and that byte is still delivered. A stop during the command or dummy phase lets exactly one data byte through. SCLK returns to its idle level when chip select rises.
- R8: A start pulse while a read is running has no effect: no new command is issued and the stream continues unbroken. A stop pulse while idle has no effect.
- R9: A start after a stop issues the full command again from START_ADDR, and the stream restarts at the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a read from idle |
| stop | input | 1 | One-cycle pulse that ends the stream at the next byte boundary |
| spi_sclk | output | 1 | SPI serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select to the flash |
| spi_mosi | output | 1 | Command and address bits to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_data | output | DATA_BITS | Most recently assembled data byte |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a new byte |

## Verification
Two instances are exercised side by side: one in mode 0 with eight dummy bits and a divider of two, and one in mode 3 with no dummy bits and a divider of one. A flash model decodes each instance's command and serves a known byte table. A design that mixed up the bit order of the opcode or address would show a wrong captured command. A design that miscounted dummy bits would deliver bytes shifted by some bits, and one that sampled on the wrong edge would do the same only in mode 3. The bench sends a stop in the middle of a byte and again during the command phase. A design that dropped chip select at once would deliver one byte too few or a truncated byte. The bench also sends a start in the middle of the stream and a stop while idle. A design that did not ignore these would issue a second command or move SCLK while deselected.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

   // Controller state: deselected, or running a read.
   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_RUN  = 1'b1
   } rd_state_t;

   // Strobes from the SCLK timer, each one system cycle wide.
   typedef struct packed {
      logic smp;      // end of first half of a bit: sample MISO here
      logic bit_end;  // end of second half of a bit: advance MOSI here
   } rd_tick_t;

endpackage

// File: rtl/spi_rd_clkgen.sv
module spi_rd_clkgen
   import spi_rd_pkg::*;
#(
   parameter int unsigned DIV = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   output rd_tick_t tk,
   output logic     half
);

   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = run && (cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         half <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         half <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         half <= ~half;
      end else begin
         cnt  <= cnt + CW'(1);
      end
   end

   assign tk.smp     = wrap && !half;
   assign tk.bit_end = wrap && half;

   AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < DIV); // R6

   AST_HALF_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !$past(wrap) |-> $stable(half)); // R6

endmodule

// File: rtl/spi_rd_cmd_tx.sv
module spi_rd_cmd_tx #(
   parameter int unsigned    W    = 32,
   parameter logic [W-1:0]   WORD = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic shift,
   output logic mosi
);

   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr <= '0;
      else if (load)   sr <= WORD;
      else if (shift)  sr <= {sr[W-2:0], 1'b0};
   end

   assign mosi = sr[W-1];

endmodule

// File: rtl/spi_rd_deser.sv
module spi_rd_deser #(
   parameter int unsigned W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 smp,
   input  logic                 en,
   input  logic                 miso,
   output logic [W-1:0]         data,
   output logic                 valid,
   output logic [$clog2(W)-1:0] bcnt
);

   localparam int unsigned BW = $clog2(W);

   logic [W-1:0] sr;
   logic         take;
   logic         last;

   assign take = smp && en;
   assign last = (bcnt == BW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         bcnt  <= '0;
         data  <= '0;
         valid <= 1'b0;
      end else if (clr) begin
         bcnt  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (take) begin
            sr   <= {sr[W-2:0], miso};
            bcnt <= last ? '0 : bcnt + BW'(1);
            if (last) begin
               data  <= {sr[W-2:0], miso};
               valid <= 1'b1;
            end
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R4

   AST_BCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(bcnt) < W); // R4

endmodule

// File: rtl/spi_stream_reader.sv
module spi_stream_reader
   import spi_rd_pkg::*;
#(
   parameter int unsigned         OPC_BITS   = 8,
   parameter int unsigned         ADDR_BITS  = 24,
   parameter int unsigned         DATA_BITS  = 8,
   parameter int unsigned         DUMMY_BITS = 8,
   parameter int unsigned         DIV        = 2,
   parameter bit                  CPOL       = 1'b0,
   parameter bit                  CPHA       = 1'b0,
   parameter logic [OPC_BITS-1:0] OPCODE     = 8'h0B,
   parameter logic [ADDR_BITS-1:0] START_ADDR = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 stop,
   output logic                 spi_sclk,
   output logic                 spi_cs_n,
   output logic                 spi_mosi,
   input  logic                 spi_miso,
   output logic [DATA_BITS-1:0] rd_data,
   output logic                 rd_valid
);

   localparam int unsigned CMD_BITS = OPC_BITS + ADDR_BITS;
   localparam int unsigned HDR      = CMD_BITS + DUMMY_BITS;
   localparam int unsigned HW       = $clog2(HDR + 1);
   localparam int unsigned BW       = $clog2(DATA_BITS);

   // Elaboration-time parameter checks.
   if (DIV < 1) begin : g_bad_div
      $error("spi_stream_reader: DIV must be at least 1");
   end
   if (DATA_BITS < 2) begin : g_bad_data
      $error("spi_stream_reader: DATA_BITS must be at least 2");
   end
   if (CMD_BITS < 2) begin : g_bad_cmd
      $error("spi_stream_reader: command must be at least 2 bits");
   end

   rd_state_t         state;
   logic              stop_pend;
   logic [HW-1:0]     hdr_cnt;
   logic              data_phase;
   logic              running;
   logic              load;
   logic              half;
   logic              phase_lvl;
   logic              at_boundary;
   logic              stop_now;
   logic [BW-1:0]     bcnt;
   rd_tick_t          tk;

   assign running    = (state == RD_RUN);
   assign load       = !running && start;
   assign data_phase = (hdr_cnt == HW'(HDR));
   assign at_boundary = data_phase && (bcnt == '0);
   assign stop_now   = running && tk.bit_end && (stop || stop_pend) && at_boundary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RD_IDLE;
         stop_pend <= 1'b0;
         hdr_cnt   <= '0;
      end else if (!running) begin
         stop_pend <= 1'b0;
         if (start) begin
            state   <= RD_RUN;
            hdr_cnt <= '0;
         end
      end else begin
         if (stop) stop_pend <= 1'b1;
         if (tk.bit_end && !data_phase) hdr_cnt <= hdr_cnt + HW'(1);
         if (stop_now) begin
            state     <= RD_IDLE;
            stop_pend <= 1'b0;
         end
      end
   end

   spi_rd_clkgen #(.DIV(DIV)) clkgen_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .tk    (tk),
      .half  (half)
   );

   spi_rd_cmd_tx #(
      .W    (CMD_BITS),
      .WORD ({OPCODE, START_ADDR})
   ) cmd_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .shift (tk.bit_end),
      .mosi  (spi_mosi)
   );

   spi_rd_deser #(.W(DATA_BITS)) deser_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (load),
      .smp   (tk.smp),
      .en    (data_phase),
      .miso  (spi_miso),
      .data  (rd_data),
      .valid (rd_valid),
      .bcnt  (bcnt)
   );

   // Clock phase variant: sampling always falls at the mid-bit transition,
   // so only the level of each half differs between the two phase options.
   if (CPHA == 1'b0) begin : g_smp_lead
      assign phase_lvl = half;
   end else begin : g_smp_trail
      assign phase_lvl = ~half;
   end

   assign spi_sclk = running ? (CPOL ^ phase_lvl) : CPOL;
   assign spi_cs_n = !running;

   AST_STOP_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> $past(data_phase) && (bcnt == '0)); // R7

   AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      running && $past(running) && !$past(tk.bit_end) |-> $stable(spi_mosi)); // R5

   AST_HDR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      running && $past(running) |-> hdr_cnt >= $past(hdr_cnt)); // R3

   AST_NO_DATA_IN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      running && !data_phase |=> !rd_valid); // R3

endmodule

// File: tb/spi_stream_reader_tb_top.sv
`timescale 1ns/1ps

module spi_flash_model #(
   parameter bit              CPOL = 1'b0,
   parameter bit              CPHA = 1'b0,
   parameter int              HDR  = 40,
   parameter logic [0:15][7:0] MEM = '0
) (
   input  logic        sclk,
   input  logic        cs_n,
   input  logic        mosi,
   output logic        miso,
   output logic [31:0] cmd,
   output int          cs_falls
);
   int cnt = 0;

   initial begin
      miso     = 1'b0;
      cmd      = '0;
      cs_falls = 0;
   end

   always @(negedge cs_n) begin
      cnt = 0;
      cmd = '0;
      cs_falls = cs_falls + 1;
   end

   always @(sclk) begin
      if (cs_n == 1'b0) begin
         if (((sclk != CPOL) ? 1'b1 : 1'b0) == !CPHA) begin
            if (cnt < 32) cmd = {cmd[30:0], mosi};
            cnt = cnt + 1;
         end else if (cnt >= HDR) begin
            miso = MEM[((cnt - HDR) / 8) % 16][7 - ((cnt - HDR) % 8)];
         end
      end
   end
endmodule

module spi_stream_reader_tb_top;

   localparam logic [0:15][7:0] VEC = {
      8'hA5, 8'h5A, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C, 8'hC3,
      8'h12, 8'h34, 8'h7E, 8'hE7, 8'h0F, 8'hF0, 8'h96, 8'h69 };
   localparam logic [31:0] CMD_A = {8'h0B, 24'h12A5C0};
   localparam logic [31:0] CMD_B = {8'h03, 24'h00F00D};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_a = 1'b0, stop_a = 1'b0, start_b = 1'b0;
   logic sclk_a, cs_a, mosi_a, miso_a, val_a;
   logic sclk_b, cs_b, mosi_b, miso_b, val_b;
   logic [7:0] dat_a, dat_b;
   logic [31:0] cmd_a, cmd_b;
   int falls_a, falls_b;

   int n_chk = 0, n_fail = 0;
   int edges_a = 0, edges_b = 0, nb_a = 0, nb_b = 0;
   int first_a = -1, first_b = -1;
   int cs_rise_a = 0;
   realtime last_rise_a = 0, per_a = 0;
   logic [7:0] got_a [0:63];
   logic [7:0] got_b [0:63];

   always #10 clk = ~clk;

   spi_stream_reader #(
      .DUMMY_BITS(8), .DIV(2), .CPOL(1'b0), .CPHA(1'b0),
      .OPCODE(8'h0B), .START_ADDR(24'h12A5C0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start_a), .stop(stop_a),
      .spi_sclk(sclk_a), .spi_cs_n(cs_a), .spi_mosi(mosi_a), .spi_miso(miso_a),
      .rd_data(dat_a), .rd_valid(val_a)
   );

   spi_stream_reader #(
      .DUMMY_BITS(0), .DIV(1), .CPOL(1'b1), .CPHA(1'b1),
      .OPCODE(8'h03), .START_ADDR(24'h00F00D)
   ) dut_m3_i (
      .clk(clk), .rst_n(rst_n), .start(start_b), .stop(1'b0),
      .spi_sclk(sclk_b), .spi_cs_n(cs_b), .spi_mosi(mosi_b), .spi_miso(miso_b),
      .rd_data(dat_b), .rd_valid(val_b)
   );

   spi_flash_model #(.CPOL(1'b0), .CPHA(1'b0), .HDR(40), .MEM(VEC)) flash_a (
      .sclk(sclk_a), .cs_n(cs_a), .mosi(mosi_a), .miso(miso_a),
      .cmd(cmd_a), .cs_falls(falls_a));

   spi_flash_model #(.CPOL(1'b1), .CPHA(1'b1), .HDR(32), .MEM(VEC)) flash_b (
      .sclk(sclk_b), .cs_n(cs_b), .mosi(mosi_b), .miso(miso_b),
      .cmd(cmd_b), .cs_falls(falls_b));

   // Monitors
   always @(posedge sclk_a) if (cs_a == 1'b0) begin
      edges_a = edges_a + 1;
      if (edges_a == 2) per_a = $realtime - last_rise_a;
      last_rise_a = $realtime;
   end
   always @(posedge sclk_b) if (cs_b == 1'b0) edges_b = edges_b + 1;
   always @(posedge cs_a) if (rst_n) cs_rise_a = cs_rise_a + 1;

   always @(negedge clk) begin
      if (val_a === 1'b1) begin
         if (first_a < 0) first_a = edges_a;
         if (nb_a < 64) got_a[nb_a] = dat_a;
         nb_a = nb_a + 1;
      end
      if (val_b === 1'b1) begin
         if (first_b < 0) first_b = edges_b;
         if (nb_b < 64) got_b[nb_b] = dat_b;
         nb_b = nb_b + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (60000) @(negedge clk);
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int nb_stop, e_stop, nb_re;
      repeat (3) @(negedge clk);
      // R1: state under reset
      chk(cs_a === 1'b1 && sclk_a === 1'b0 && val_a === 1'b0 && mosi_a === 1'b0,
          "R1 reset mode0 outputs", {cs_a, sclk_a, val_a, mosi_a}, 4'b1000);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(cs_a === 1'b1 && sclk_a === 1'b0, "R1 idle mode0", {cs_a, sclk_a}, 2'b10);
      chk(cs_b === 1'b1 && sclk_b === 1'b1 && val_b === 1'b0,
          "R1 idle mode3", {cs_b, sclk_b, val_b}, 3'b110);

      start_a = 1'b1; start_b = 1'b1;
      @(negedge clk);
      start_a = 1'b0; start_b = 1'b0;

      // R8: start while running is ignored
      while (nb_a < 4) @(negedge clk);
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;

      while (nb_a < 16 || nb_b < 16) @(negedge clk);

      // R4 / R5: walk the byte table for both modes
      for (int i = 0; i < 16; i++) begin
         chk(got_a[i] === VEC[i], "R4 mode0 byte", got_a[i], VEC[i]);
         chk(got_b[i] === VEC[i], "R5 mode3 byte", got_b[i], VEC[i]);
      end

      chk(cmd_a === CMD_A, "R2 command mode0", cmd_a, CMD_A);
      chk(cmd_b === CMD_B, "R2 command mode3", cmd_b, CMD_B);
      chk(first_a == 48, "R3 clocks before first byte mode0", first_a, 48);
      chk(first_b == 40, "R3 clocks before first byte mode3", first_b, 40);
      chk(per_a == 80.0, "R6 sclk period", int'(per_a), 80);
      chk(falls_a == 1 && cs_rise_a == 0, "R8 single command, cs held",
          {falls_a[15:0], cs_rise_a[15:0]}, 32'h0001_0000);
      chk(cs_a === 1'b0, "R4 cs held low while streaming", cs_a, 0);

      // R7: stop in the middle of a byte
      begin
         int cur;
         cur = nb_a;
         while (nb_a == cur) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      nb_stop = nb_a;
      stop_a = 1'b1;
      @(negedge clk);
      stop_a = 1'b0;
      @(posedge cs_a);
      @(negedge clk);
      chk(nb_a == nb_stop + 1, "R7 byte in progress delivered", nb_a, nb_stop + 1);
      chk(got_a[nb_stop] === VEC[nb_stop % 16], "R7 last byte value",
          got_a[nb_stop], VEC[nb_stop % 16]);
      chk(((edges_a - 40) % 8) == 0, "R7 stop on byte boundary", edges_a, 40 + 8 * nb_a);
      repeat (4) @(negedge clk);
      chk(sclk_a === 1'b0 && cs_a === 1'b1, "R7 sclk idle after stop",
          {sclk_a, cs_a}, 2'b01);

      // R8: stop while idle
      e_stop = edges_a;
      stop_a = 1'b1;
      @(negedge clk);
      stop_a = 1'b0;
      repeat (50) @(negedge clk);
      chk(cs_a === 1'b1 && edges_a == e_stop, "R8 stop while idle ignored",
          edges_a, e_stop);

      // R9 and R7: restart, then stop during the command phase
      nb_re = nb_a;
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      repeat (5) @(negedge clk);
      stop_a = 1'b1;
      @(negedge clk);
      stop_a = 1'b0;
      @(posedge cs_a);
      repeat (4) @(negedge clk);
      chk(falls_a == 2 && cmd_a === CMD_A, "R9 command reissued", cmd_a, CMD_A);
      chk(nb_a == nb_re + 1, "R7 stop in header passes one byte", nb_a, nb_re + 1);
      chk(got_a[nb_re] === VEC[0], "R9 stream restarts at first byte",
          got_a[nb_re], VEC[0]);

      finish_run();
   end

endmodule